// File: doc/BRIEF.md
# Terminal Transmit Register Port

This block is the transmit side of a bus-mapped terminal interface. Software sees two 16-bit registers on a small register bus: a control/status word that shows whether the port can take another character and whether it may interrupt, and a data buffer that holds the character to print. A write to the data buffer hands the character to a downstream byte sink (a serializer, for instance) over a valid/ready handshake. When the sink accepts it, the port flags itself ready again and, if enabled, raises an interrupt request.

The bus carries a two-bit address, a byte-access flag, read and write strobes, write data and combinational read data. Address bit 1 picks the register (0 = control/status, 1 = data buffer). Address bit 0 names the odd byte, and counts only when the byte-access flag is high; a word access is always treated as even. A mode input picks whether 7 or 8 bits of the character reach the sink.

Sequencing is a two-state machine. In IDLE nothing is offered to the sink. The transition IDLE to SEND is taken on any buffer write. In SEND the character is offered with the valid flag held high; the transition SEND to SEND is taken while the sink stalls, and also on a new buffer write, which restarts the transfer with the new contents. The transition SEND to IDLE is taken when the sink accepts and no buffer write arrives in the same cycle.

Top module: `term_tx_port`

## Requirements
- R1: After reset the control/status word reads 0x0080 (ready set, enable clear), the buffer reads 0x0000, the interrupt request is low and no character is offered (state IDLE).
- R2: Address bit 1 selects the register: 0 gives the control/status word, 1 gives the data buffer zero-extended to 16 bits. In the control/status word bit 7 is ready (done), bit 6 is interrupt enable, and every other bit reads 0.
- R3: Only bit 6 of the control/status word is writable; write data in any other bit has no effect, and a byte write to the odd byte (byte flag 1, address bit 0 = 1) leaves the word unchanged.
- R4: Writing enable = 0 drops the interrupt request on the next cycle. Writing enable = 1 while enable was clear and ready is set raises the request on the next cycle.
- R5: Reading the data buffer returns the last loaded character and changes neither ready nor the interrupt request.
- R6: A buffer write loads bits 7:0 of the write data only for a word write or an even-byte write. Every buffer write, odd byte included, clears ready and the interrupt request and offers the buffer to the sink from the next cycle (IDLE to SEND).
- R7: The character offered to the sink is the buffer with bit 7 forced to 0 when the mode input is 0, and the full 8 bits when it is 1.
- R8: While the sink holds ready low the character stays offered and ready stays clear. The cycle after acceptance ready is set, the offer is withdrawn (SEND to IDLE), and the interrupt request rises if enable is set.
- R9: A buffer write while a character is still offered replaces it and the new character is the one delivered; the old one is never delivered.
- R10: Reset during a transfer withdraws the offer, so the pending character is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Bit 1 register select, bit 0 odd byte |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read |
| mode_full | input | 1 | 1 = send 8 bits, 0 = send 7 bits |
| tx_data | output | 8 | Character offered to the sink |
| tx_valid | output | 1 | Character offered |
| tx_ready | input | 1 | Sink accepts this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a buffer write landing on a transfer that the sink is still stalling, because the replaced character must vanish without ever being handed over. The stimulus holds the sink's ready low, writes one character, then writes another and changes the mode input before releasing ready, so the scoreboard expects exactly one delivery carrying the second character under the final mask. A reset issued while a stalled character is offered is driven the same way, and the scoreboard then expects no delivery at all.

// File: rtl/tx_port_pkg.sv
package tx_port_pkg;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    localparam int CSR_DONE_BIT = 7;
    localparam int CSR_IE_BIT   = 6;
    localparam int SEL_BIT      = 1;
    localparam int ODD_BIT      = 0;

endpackage

// File: rtl/tx_bus_decode.sv
module tx_bus_decode
    import tx_port_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_acc,
    input  logic              wr,
    output logic              sel_buf,
    output logic              csr_wr,
    output logic              buf_wr,
    output logic              buf_load
);

    logic odd_byte;

    always_comb begin
        sel_buf  = addr[SEL_BIT];
        odd_byte = byte_acc & addr[ODD_BIT];
        csr_wr   = wr & ~sel_buf & ~odd_byte;
        buf_wr   = wr & sel_buf;
        buf_load = wr & sel_buf & ~odd_byte;
    end

endmodule

// File: rtl/tx_char_buf.sv
module tx_char_buf #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              mode_full,
    output logic [CHAR_W-1:0] buf_q,
    output logic [CHAR_W-1:0] tx_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (load) begin
            buf_q <= wdata;
        end
    end

    generate
        if (CHAR_W > 1) begin : g_mask
            assign tx_data = mode_full ? buf_q : {1'b0, buf_q[CHAR_W-2:0]};
        end else begin : g_plain
            assign tx_data = buf_q;
        end
    endgenerate

endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
    import tx_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sink_ready,
    output logic offer,
    output logic accept
);

    tx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (start) state_d = TX_SEND;
            TX_SEND: begin
                if (start)           state_d = TX_SEND;
                else if (sink_ready) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        offer  = (state_q == TX_SEND);
        accept = offer & sink_ready;
    end

endmodule

// File: rtl/tx_status.sv
module tx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic csr_wr,
    input  logic wr_ie,
    input  logic buf_wr,
    input  logic accept,
    output logic done,
    output logic ie,
    output logic irq
);

    logic ie_eff;

    always_comb begin
        ie_eff = csr_wr ? wr_ie : ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b1;
            ie   <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (csr_wr) ie <= wr_ie;
            if (buf_wr) begin
                done <= 1'b0;
                irq  <= 1'b0;
            end else begin
                if (accept) done <= 1'b1;
                if (csr_wr && !wr_ie)                  irq <= 1'b0;
                else if (accept && ie_eff)             irq <= 1'b1;
                else if (csr_wr && wr_ie && !ie && done) irq <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/term_tx_port.sv
module term_tx_port
    import tx_port_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int BUS_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_byte,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              mode_full,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              irq
);

    logic              sel_buf, csr_wr, buf_wr, buf_load;
    logic              accept;
    logic              done_q, ie_q;
    logic [CHAR_W-1:0] buf_q;

    tx_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .byte_acc (bus_byte),
        .wr       (bus_wr),
        .sel_buf  (sel_buf),
        .csr_wr   (csr_wr),
        .buf_wr   (buf_wr),
        .buf_load (buf_load)
    );

    tx_char_buf #(.CHAR_W(CHAR_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (buf_load),
        .wdata     (bus_wdata[CHAR_W-1:0]),
        .mode_full (mode_full),
        .buf_q     (buf_q),
        .tx_data   (tx_data)
    );

    tx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (buf_wr),
        .sink_ready (tx_ready),
        .offer      (tx_valid),
        .accept     (accept)
    );

    tx_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .csr_wr (csr_wr),
        .wr_ie  (bus_wdata[CSR_IE_BIT]),
        .buf_wr (buf_wr),
        .accept (accept),
        .done   (done_q),
        .ie     (ie_q),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_buf) begin
                bus_rdata[CHAR_W-1:0] = buf_q;
            end else begin
                bus_rdata[CSR_DONE_BIT] = done_q;
                bus_rdata[CSR_IE_BIT]   = ie_q;
            end
        end
    end

endmodule

// File: rtl/tx_port_chk.sv
module tx_port_chk
    import tx_port_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int BUS_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_byte,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              irq,
    input logic              done,
    input logic              ie
);

    logic is_buf_wr, is_csr_even_wr, is_csr_odd_wr, is_buf_rd;

    always_comb begin
        is_buf_wr      = bus_wr & bus_addr[SEL_BIT];
        is_csr_odd_wr  = bus_wr & ~bus_addr[SEL_BIT] & bus_byte & bus_addr[ODD_BIT];
        is_csr_even_wr = bus_wr & ~bus_addr[SEL_BIT] & ~(bus_byte & bus_addr[ODD_BIT]);
        is_buf_rd      = bus_rd & ~bus_wr & bus_addr[SEL_BIT];
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && ie)); // R4

    AST_IE_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_csr_even_wr && !bus_wdata[CSR_IE_BIT]) |=> !irq); // R4

    AST_ODD_CSR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        is_csr_odd_wr |=> $stable(ie)); // R3

    AST_BUFWR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        is_buf_wr |=> (tx_valid && !done && !irq)); // R6

    AST_BUFRD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (is_buf_rd && !(tx_valid && tx_ready)) |=> ($stable(done) && $stable(irq))); // R5

    AST_RETRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid); // R8

    AST_NO_DONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !done); // R8

    AST_ACCEPT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !is_buf_wr) |=> (done && !tx_valid)); // R8

endmodule

bind term_tx_port tx_port_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_byte  (bus_byte),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .irq       (irq),
    .done      (done_q),
    .ie        (ie_q)
);

// File: tb/tb_term_tx_port.sv
`timescale 1ns/100ps
module tb_term_tx_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_byte = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mode_full = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int delivered = 0;
    bit ended = 0;
    logic [7:0] model_buf = 8'h00;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    term_tx_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_byte(bus_byte),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mode_full(mode_full), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard when the sink takes a character
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk("R9", "unexpected delivery", {8'h00, tx_data}, 16'hFFFF);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (!mode_full) e[7] = 1'b0;
                chk("R7", "delivered char", {8'h00, tx_data}, {8'h00, e});
                delivered++;
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic byt, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_byte = byt; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        bus_addr = a; bus_byte = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // Driver: pushes or replaces the expected character, then writes
    task automatic tx_write(input logic byt, input logic odd, input logic [15:0] d,
                            input bit replace);
        if (!(byt && odd)) model_buf = d[7:0];
        if (replace && exp_q.size() > 0) exp_q[exp_q.size()-1] = model_buf;
        else exp_q.push_back(model_buf);
        bus_write({1'b1, odd}, byt, d);
    endtask

    task automatic set_ready(input logic r);
        @(posedge clk); #1;
        tx_ready = r;
    endtask

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        @(negedge clk);
        chk("R1", "irq after reset", {15'h0, irq}, 16'h0);
        chk("R1", "valid after reset", {15'h0, tx_valid}, 16'h0);
        bus_read(2'b00, v); chk("R1", "csr after reset", v, 16'h0080);
        bus_read(2'b10, v); chk("R1", "buffer after reset", v, 16'h0000);

        bus_write(2'b00, 1'b0, 16'hFFFF);
        @(negedge clk); chk("R4", "irq on enable", {15'h0, irq}, 16'h1);
        bus_read(2'b00, v); chk("R3", "only enable writable", v, 16'h00C0);
        chk("R2", "csr bit layout", v & 16'hFF3F, 16'h0000);

        bus_write(2'b00, 1'b0, 16'h0000);
        @(negedge clk); chk("R4", "irq after disable", {15'h0, irq}, 16'h0);
        bus_write(2'b01, 1'b1, 16'hFFFF);
        bus_read(2'b00, v); chk("R3", "odd csr write ignored", v, 16'h0080);
        chk("R3", "irq after odd write", {15'h0, irq}, 16'h0);
        bus_write(2'b00, 1'b0, 16'h0040);
        @(negedge clk); chk("R4", "irq on re-enable", {15'h0, irq}, 16'h1);

        // stalled transfer
        tx_write(1'b0, 1'b0, 16'h1234, 0);
        @(negedge clk);
        chk("R6", "valid after write", {15'h0, tx_valid}, 16'h1);
        chk("R6", "irq after write", {15'h0, irq}, 16'h0);
        chk("R6", "offered char", {8'h00, tx_data}, 16'h0034);
        repeat (4) @(posedge clk);
        @(negedge clk); chk("R8", "valid held in stall", {15'h0, tx_valid}, 16'h1);
        bus_read(2'b00, v); chk("R8", "done clear in stall", v, 16'h0040);
        bus_read(2'b10, v); chk("R5", "buffer readback", v, 16'h0034);
        bus_read(2'b00, v); chk("R5", "csr after buffer read", v, 16'h0040);

        // replace while stalled, then change mode
        tx_write(1'b0, 1'b0, 16'h00C5, 1);
        @(negedge clk); chk("R9", "replaced char", {8'h00, tx_data}, 16'h00C5);
        @(posedge clk); #1 mode_full = 1'b0;
        @(negedge clk); chk("R7", "7-bit mask", {8'h00, tx_data}, 16'h0045);

        set_ready(1'b1);
        bus_read(2'b00, v); chk("R8", "done after accept", v, 16'h00C0);
        chk("R8", "irq after accept", {15'h0, irq}, 16'h1);
        chk("R8", "offer withdrawn", {15'h0, tx_valid}, 16'h0);

        // odd-byte buffer write resends old char
        tx_write(1'b1, 1'b1, 16'hAB00, 0);
        bus_read(2'b10, v); chk("R6", "odd write keeps buffer", v, 16'h00C5);
        bus_read(2'b00, v); chk("R6", "odd write completes", v, 16'h00C0);

        // even-byte write, 8-bit mode
        @(posedge clk); #1 mode_full = 1'b1;
        tx_write(1'b1, 1'b0, 16'h3377, 0);
        bus_read(2'b10, v); chk("R6", "even byte loads", v, 16'h0077);

        // completion with enable clear
        bus_write(2'b00, 1'b0, 16'h0000);
        tx_write(1'b0, 1'b0, 16'h0042, 0);
        bus_read(2'b00, v); chk("R8", "done without enable", v, 16'h0080);
        chk("R8", "no irq without enable", {15'h0, irq}, 16'h0);

        // reset during a stalled transfer
        set_ready(1'b0);
        tx_write(1'b0, 1'b0, 16'h0011, 0);
        @(posedge clk); #1 rst_n = 1'b0;
        exp_q.delete(); model_buf = 8'h00;
        @(posedge clk); #1 rst_n = 1'b1;
        set_ready(1'b1);
        @(negedge clk); chk("R10", "offer cancelled", {15'h0, tx_valid}, 16'h0);
        bus_read(2'b00, v); chk("R1", "csr after mid reset", v, 16'h0080);
        bus_read(2'b10, v); chk("R1", "buffer after mid reset", v, 16'h0000);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "scoreboard drained", 16'(exp_q.size()), 16'h0);
        chk("R10", "delivery count", 16'(delivered), 16'd4);
        finish_up();
    end

endmodule